// File: doc/BRIEF.md
# Walsh-Hadamard Multi-User Spreader

This block spreads QPSK data for a multicarrier CDMA downlink. For one data index, every active user delivers one QPSK symbol. The block combines the symbols of all users into a single vector of chips. Each user's symbol is weighted by that user's Walsh-Hadamard code row, and the weighted rows are summed.

The block does not multiply by each code separately. It runs one fast Hadamard transform over the user vector, with a separate but identical butterfly network for the I part and the Q part. Every butterfly stage widens the word by one bit, so a chip can never overflow. The transform is repeated once for each data index of a multicarrier symbol. Loading a group of users, transforming it and sending the result is therefore one "group".

Symbols enter over a valid/ready handshake, each carrying a user index. A flag marks the final symbol of the group. One cycle later the block emits NU chips, one per cycle in chip-index order, with a last flag on the final chip. While a group is being transformed or sent, no input is taken.

Top module: `wh_spreader`

## Requirements
- R1: After reset, `out_valid` and `out_last` are 0 and `in_ready` is 1.
- R2: Chip k is the sum, over active users j, of s_j·(-1)^popcount(j AND k), computed separately for I and Q. Here `in_sym` bit 0 gives the I sign and bit 1 gives the Q sign, with 0 mapping to +1 and 1 mapping to -1.
- R3: The chip width is log2(NU)+2 signed bits. When all NU users send the same symbol, chip 0 equals +NU or -NU and every other chip is 0, with no overflow.
- R4: A user index that received no symbol in the current group contributes zero to every chip.
- R5: The NU chips of a group leave on consecutive cycles in index order 0..NU-1. `out_last` is 1 only with chip NU-1, and `out_valid` is 0 in the cycle after it.
- R6: If the symbol with `in_last` is accepted at clock edge E, `out_valid` is 0 after E and 1 from edge E+1 onward, for NU cycles.
- R7: `in_ready` is 0 from the acceptance of `in_last` until the cycle after the last chip. Inputs offered in that time have no effect on any chip.
- R8: If the same user index is written twice in one group, the later symbol replaces the earlier one.
- R9: A group starts with every user inactive. Symbols from earlier groups do not appear in later groups.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | Input symbol offered |
| in_ready | output | 1 | Block accepts a symbol this cycle |
| in_user | input | log2(NU) | User index, which selects the code row |
| in_sym | input | 2 | QPSK bits: bit 0 = I sign, bit 1 = Q sign |
| in_last | input | 1 | Final symbol of the group |
| out_valid | output | 1 | Chip valid |
| out_i | output | log2(NU)+2 | Signed I chip |
| out_q | output | log2(NU)+2 | Signed Q chip |
| out_last | output | 1 | Final chip of the group |

## Verification
A stale or wrongly written user slot shows up at once: every chip of the next group differs from the Hadamard sum, often in several positions, because each user touches all NU chips. A butterfly with the wrong sign or pairing corrupts a predictable subset of chip indices within the same group. Errors in the counter or the state machine move `out_valid` or `out_last` by a cycle, or let a blocked input leak into the following group. The bench observes both of these within one group of NU+2 cycles.

// File: rtl/wh_pkg.sv
// Shared types and helpers for the Walsh-Hadamard spreader.
package wh_pkg;

    // Control phase of the spreader.
    typedef enum logic [1:0] {
        ST_LOAD = 2'd0,
        ST_CALC = 2'd1,
        ST_SEND = 2'd2
    } wh_state_e;

    // Maps one QPSK bit to a bipolar level: 0 -> +1, 1 -> -1.
    function automatic logic signed [1:0] qpsk_level(input logic b);
        return b ? -2'sd1 : 2'sd1;
    endfunction

endpackage

// File: rtl/wh_slot_bank.sv
// Per-user symbol store. Each slot holds a bipolar I and Q level, or zero
// when the user is inactive. A write replaces the slot of its user index.
// A clear sets all slots to zero.
// Assumes: clear and write never fall in the same cycle.
module wh_slot_bank #(
    parameter int NU = 8,
    localparam int UW = $clog2(NU)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            wr,
    input  logic [UW-1:0]   wr_user,
    input  logic [1:0]      wr_sym,
    input  logic            clr,
    output logic [2*NU-1:0] vec_i,
    output logic [2*NU-1:0] vec_q
);
    import wh_pkg::*;

    logic signed [1:0] slot_i [NU];
    logic signed [1:0] slot_q [NU];

    // Slot update: reset or clear zeroes every slot; a write loads one slot.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            for (int j = 0; j < NU; j++) begin
                slot_i[j] <= '0;
                slot_q[j] <= '0;
            end
        end else if (wr) begin
            slot_i[wr_user] <= qpsk_level(wr_sym[0]);
            slot_q[wr_user] <= qpsk_level(wr_sym[1]);
        end
    end

    for (genvar j = 0; j < NU; j++) begin : g_flat
        assign vec_i[2*j +: 2] = slot_i[j];
        assign vec_q[2*j +: 2] = slot_q[j];
    end

    // After a clear, every user must read as inactive.
    p_cleared_r9: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (vec_i == '0 && vec_q == '0));

endmodule

// File: rtl/wh_fht_core.sv
// Combinational fast Hadamard transform in natural (Sylvester) order.
// It has log2(NU) butterfly stages, and each stage adds one bit of headroom,
// so a 2-bit input leaves as log2(NU)+2 bits without overflow.
// Assumes: NU is a power of two, at least 2.
module wh_fht_core #(
    parameter int NU = 8,
    localparam int L  = $clog2(NU),
    localparam int OW = L + 2
) (
    input  logic [2*NU-1:0]  x_flat,
    output logic [OW*NU-1:0] y_flat
);
    logic signed [OW-1:0] lvl [L+1][NU];

    for (genvar k = 0; k < NU; k++) begin : g_in
        assign lvl[0][k] = OW'($signed(x_flat[2*k +: 2]));
        assign y_flat[OW*k +: OW] = lvl[L][k];
    end

    for (genvar s = 0; s < L; s++) begin : g_stage
        localparam int HALF = 1 << s;
        for (genvar k = 0; k < NU; k++) begin : g_bfly
            if ((k & HALF) == 0) begin : g_sum
                assign lvl[s+1][k] = lvl[s][k] + lvl[s][k+HALF];
            end else begin : g_diff
                assign lvl[s+1][k] = lvl[s][k-HALF] - lvl[s][k];
            end
        end
    end

endmodule

// File: rtl/wh_chip_serializer.sv
// Holds one transformed chip vector and sends it one chip per cycle in index
// order, flagging the final chip.
// Assumes: load arrives only while idle.
module wh_chip_serializer #(
    parameter int NU = 8,
    localparam int L  = $clog2(NU),
    localparam int OW = L + 2
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 load,
    input  logic [OW*NU-1:0]     chips_i,
    input  logic [OW*NU-1:0]     chips_q,
    output logic                 out_valid,
    output logic signed [OW-1:0] out_i,
    output logic signed [OW-1:0] out_q,
    output logic                 out_last
);
    logic signed [OW-1:0] hold_i [NU];
    logic signed [OW-1:0] hold_q [NU];
    logic [L-1:0]         cnt;
    logic                 busy;

    // Chip store: capture the whole vector when loading.
    always_ff @(posedge clk) begin
        if (load) begin
            for (int k = 0; k < NU; k++) begin
                hold_i[k] <= chips_i[OW*k +: OW];
                hold_q[k] <= chips_q[OW*k +: OW];
            end
        end
    end

    // Chip counter: run 0..NU-1 after a load, then go idle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy <= 1'b0;
            cnt  <= '0;
        end else if (load) begin
            busy <= 1'b1;
            cnt  <= '0;
        end else if (busy) begin
            cnt <= cnt + 1'b1;
            if (cnt == L'(NU - 1)) begin
                busy <= 1'b0;
            end
        end
    end

    assign out_valid = busy;
    assign out_last  = busy && (cnt == L'(NU - 1));
    assign out_i     = busy ? hold_i[cnt] : '0;
    assign out_q     = busy ? hold_q[cnt] : '0;

    // Output starts with chip 0 right after the load.
    p_first_chip_r6: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> (out_valid && cnt == '0));
    // The final chip ends the burst.
    p_burst_end_r5: assert property (@(posedge clk) disable iff (!rst_n)
        out_last |=> !out_valid);
    // Chips stay inside +/-NU.
    p_no_overflow_r3: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> (out_i >= -NU && out_i <= NU && out_q >= -NU && out_q <= NU));

endmodule

// File: rtl/wh_spreader.sv
// Top of the Walsh-Hadamard multi-user spreader. It gathers one QPSK symbol
// per user, transforms the I and Q vectors, and sends NU chips.
// Assumes: NU is a power of two, at least 2. The output has no backpressure.
module wh_spreader #(
    parameter int NU = 8,
    localparam int UW = $clog2(NU),
    localparam int OW = UW + 2
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 in_valid,
    output logic                 in_ready,
    input  logic [UW-1:0]        in_user,
    input  logic [1:0]           in_sym,
    input  logic                 in_last,
    output logic                 out_valid,
    output logic signed [OW-1:0] out_i,
    output logic signed [OW-1:0] out_q,
    output logic                 out_last
);
    import wh_pkg::*;

    wh_state_e        state;
    logic             acc, acc_last, calc;
    logic [2*NU-1:0]  vec_i, vec_q;
    logic [OW*NU-1:0] chips_i, chips_q;

    assign in_ready = (state == ST_LOAD);
    assign acc      = in_valid && in_ready;
    assign acc_last = acc && in_last;
    assign calc     = (state == ST_CALC);

    // Phase control: load, one transform cycle, then send.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= ST_LOAD;
        end else begin
            unique case (state)
                ST_LOAD: if (acc_last) state <= ST_CALC;
                ST_CALC: state <= ST_SEND;
                ST_SEND: if (out_last) state <= ST_LOAD;
                default: state <= ST_LOAD;
            endcase
        end
    end

    wh_slot_bank #(.NU(NU)) u_slots (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr      (acc),
        .wr_user (in_user),
        .wr_sym  (in_sym),
        .clr     (calc),
        .vec_i   (vec_i),
        .vec_q   (vec_q)
    );

    wh_fht_core #(.NU(NU)) u_fht_i (.x_flat(vec_i), .y_flat(chips_i));
    wh_fht_core #(.NU(NU)) u_fht_q (.x_flat(vec_q), .y_flat(chips_q));

    wh_chip_serializer #(.NU(NU)) u_ser (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (calc),
        .chips_i   (chips_i),
        .chips_q   (chips_q),
        .out_valid (out_valid),
        .out_i     (out_i),
        .out_q     (out_q),
        .out_last  (out_last)
    );

    // Output and input acceptance never overlap.
    p_ready_blocked_r7: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> !in_ready);
    // One quiet cycle follows the closing symbol.
    p_calc_gap_r6: assert property (@(posedge clk) disable iff (!rst_n)
        acc_last |=> (!out_valid && !in_ready));
    // The last flag only travels with a valid chip.
    p_last_valid_r5: assert property (@(posedge clk) disable iff (!rst_n)
        out_last |-> out_valid);

endmodule

// File: tb/sim_wh_spreader.sv
module sim_wh_spreader;
    localparam int NU = 8;
    localparam int UW = $clog2(NU);
    localparam int OW = UW + 2;

    logic                 clk = 1'b0;
    logic                 rst_n = 1'b0;
    logic                 in_valid = 1'b0;
    logic                 in_ready;
    logic [UW-1:0]        in_user = '0;
    logic [1:0]           in_sym = '0;
    logic                 in_last = 1'b0;
    logic                 out_valid;
    logic signed [OW-1:0] out_i, out_q;
    logic                 out_last;

    int n_chk = 0;
    int n_err = 0;
    bit done = 1'b0;

    int mi [NU];
    int mq [NU];
    int gu [32];
    int gs [32];
    int gn;

    always #10 clk = ~clk;

    wh_spreader #(.NU(NU)) u0 (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
        .in_user(in_user), .in_sym(in_sym), .in_last(in_last),
        .out_valid(out_valid), .out_i(out_i), .out_q(out_q), .out_last(out_last)
    );

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    function automatic int lvl(input int b);
        return (b != 0) ? -1 : 1;
    endfunction

    function automatic int exp_chip(input int k, input bit q);
        int s = 0;
        for (int j = 0; j < NU; j++) begin
            int v = q ? mq[j] : mi[j];
            s += ($countones(j & k) % 2 == 1) ? -v : v;
        end
        return s;
    endfunction

    // Sends the group held in gu/gs/gn and checks timing and every chip (R2, R5-R7).
    task automatic run_group(input string name);
        for (int i = 0; i < gn; i++) begin
            if ($urandom_range(3) == 0) begin
                @(negedge clk);
                in_valid = 1'b0;
            end
            @(negedge clk);
            in_valid = 1'b1;
            in_user  = UW'(gu[i]);
            in_sym   = 2'(gs[i]);
            in_last  = (i == gn - 1);
            mi[gu[i]] = lvl(gs[i] & 1);
            mq[gu[i]] = lvl((gs[i] >> 1) & 1);
        end
        @(negedge clk);
        chk(!out_valid, {name, " R6 no chip in calc cycle"}, int'(out_valid), 0);
        chk(!in_ready, {name, " R7 ready low after last"}, int'(in_ready), 0);
        // R7: junk offered while busy must be ignored
        in_valid = 1'b1;
        in_user  = '0;
        in_sym   = 2'b11;
        in_last  = 1'b1;
        for (int k = 0; k < NU; k++) begin
            @(negedge clk);
            chk(out_valid === 1'b1, {name, " R6 valid burst"}, int'(out_valid), 1);
            chk(out_last === (k == NU - 1), {name, " R5 last flag"}, int'(out_last), int'(k == NU - 1));
            chk(int'(out_i) == exp_chip(k, 1'b0), {name, " R2 I chip"}, int'(out_i), exp_chip(k, 1'b0));
            chk(int'(out_q) == exp_chip(k, 1'b1), {name, " R2 Q chip"}, int'(out_q), exp_chip(k, 1'b1));
            chk(!in_ready, {name, " R7 ready low while sending"}, int'(in_ready), 0);
            if (k == NU - 1) in_valid = 1'b0;
        end
        in_last = 1'b0;
        @(negedge clk);
        chk(!out_valid, {name, " R5 burst ended"}, int'(out_valid), 0);
        chk(in_ready, {name, " R7 ready back"}, int'(in_ready), 1);
        // R9: each new group starts empty
        for (int j = 0; j < NU; j++) begin
            mi[j] = 0;
            mq[j] = 0;
        end
    endtask

    initial begin
        for (int j = 0; j < NU; j++) begin
            mi[j] = 0;
            mq[j] = 0;
        end
        void'($urandom(32'd4711));
        repeat (3) @(negedge clk);
        // R1 reset state
        chk(!out_valid, "R1 out_valid after reset", int'(out_valid), 0);
        chk(!out_last, "R1 out_last after reset", int'(out_last), 0);
        chk(in_ready, "R1 in_ready after reset", int'(in_ready), 1);
        rst_n = 1'b1;

        // R3: all users +1 gives +NU at chip 0
        gn = NU;
        for (int j = 0; j < NU; j++) begin gu[j] = j; gs[j] = 0; end
        run_group("R3 all plus");
        // R3: all users -1 gives -NU at chip 0
        for (int j = 0; j < NU; j++) begin gu[j] = NU - 1 - j; gs[j] = 3; end
        run_group("R3 all minus");
        // R4: single active user 5, others inactive
        gn = 1; gu[0] = 5; gs[0] = 2;
        run_group("R4 single user");
        // R8: user 2 written twice, later symbol wins
        gn = 3; gu[0] = 2; gs[0] = 0; gu[1] = 6; gs[1] = 1; gu[2] = 2; gs[2] = 3;
        run_group("R8 overwrite");
        // R9: a short group right after a full one must not see old users
        gn = NU;
        for (int j = 0; j < NU; j++) begin gu[j] = j; gs[j] = 1; end
        run_group("R9 full");
        gn = 1; gu[0] = 0; gs[0] = 2;
        run_group("R9 after full");

        // Random groups: random subsets, order and repeats (R2, R4, R8)
        for (int g = 0; g < 25; g++) begin
            gn = 1 + $urandom_range(NU + 3);
            for (int i = 0; i < gn; i++) begin
                gu[i] = $urandom_range(NU - 1);
                gs[i] = $urandom_range(3);
            end
            run_group("R2 random");
        end

        if (!done) begin
            done = 1'b1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_err);
            $finish;
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            n_chk++;
            n_err++;
            $display("FAIL watchdog R5 actual=%0d expected=%0d", 1, 0);
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_err);
            $finish;
        end
    end
endmodule